// File: doc/BRIEF.md
# Mealy Machine Equivalence Miter

This block runs two Mealy machines side by side on a single serial input bit and flags the first time their outputs disagree. The first machine is a six-state reference machine. The second is its reduced form with four states, one per equivalence class of the reference machine. The block is used to show which pairs of starting states are equivalent and which can be told apart.

Each machine has its own start-state select. On every accepted input bit both machines take the same bit. An XOR of their output bits drives a mismatch flag. A sticky error flag records that a mismatch has happened, and a small counter records the input index at which it first happened.

The input bit arrives on a valid/ready interface. `in_ready` is low while reset is high and high at all other times. A bit is accepted on a rising clock edge only when both `in_valid` and `in_ready` are high. A producer may hold `in_valid` low for any number of cycles, and nothing advances during that time. Because the outputs are Mealy outputs, `z_a`, `z_b` and `mismatch` belong to the bit currently offered, in the same cycle.

Top module: `mealy_miter`

## Requirements
- R1: While `rst` is high at a rising edge, machine A loads its start state from `sel_a` and the reduced machine loads the class of `sel_b`, using the codes 0=A, 1=B, 2=C, 3=D, 4=E, 5=F. Codes 6 and 7 select A. The same edge clears `err_flag` and `first_idx`, and `in_ready` is low while `rst` is high.
- R2: Machine A follows this table (next state and z): A: x0→E/0, x1→D/1. B: x0→F/0, x1→D/0. C: x0→E/0, x1→B/1. D: x0→F/0, x1→B/0. E: x0→C/0, x1→F/1. F: x0→B/0, x1→C/0. `z_a` shows the z of the offered bit.
- R3: The reduced machine has the four classes {A,C}, {E}, {B,D} and {F}. For every input sequence, `z_b` equals the z that the six-state table gives when it starts from the state selected by `sel_b`.
- R4: `mismatch` is `z_a` XOR `z_b` in any cycle where a bit is offered and accepted, and it is 0 in every other cycle.
- R5: `err_flag` goes high on the edge after the first mismatch, and it stays high until the next reset.
- R6: `first_idx` gives the number of bits accepted before the first mismatching bit, saturating at 7. It does not change after `err_flag` is set.
- R7: A cycle without an accepted bit does not change either machine's state or the bit count.
- R8: Start pairs taken from the same class never cause a mismatch, for any input sequence.
- R9: Starting from A and E, the input sequence 1,1,1 gives its first mismatch on the third bit. Starting from A and B, the first bit 1 gives a mismatch at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the start states |
| sel_a | input | 3 | Start-state code for the six-state machine |
| sel_b | input | 3 | Start-state code for the reduced machine |
| in_valid | input | 1 | An input bit is offered |
| in_ready | output | 1 | The block can accept a bit (low during reset) |
| in_bit | input | 1 | Serial input bit x |
| z_a | output | 1 | Mealy output of the six-state machine |
| z_b | output | 1 | Mealy output of the reduced machine |
| mismatch | output | 1 | Outputs differ on the accepted bit |
| err_flag | output | 1 | Sticky: a mismatch has happened since reset |
| first_idx | output | 3 | Index of the first mismatching bit, saturating |

## Verification
The assertions assume that `in_valid` and `in_bit` carry known values whenever `rst` is low. They also assume that the start selects are valid while reset is held, since only the value at the reset edge matters. The bench drives every input at the falling edge, holds the selects steady across each reset, and offers only 0 or 1 on `in_bit`. Idle cycles are added by lowering `in_valid`, never by leaving the input undriven, so every state step the properties reason about comes from a defined bit.

// File: rtl/mealy_miter_pkg.sv
package mealy_miter_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    ST_A = 3'd0,
    ST_B = 3'd1,
    ST_C = 3'd2,
    ST_D = 3'd3,
    ST_E = 3'd4,
    ST_F = 3'd5
  } full_st_t;

  typedef enum logic [1:0] {
    CL_AC = 2'd0,
    CL_E  = 2'd1,
    CL_BD = 2'd2,
    CL_F  = 2'd3
  } cls_t;

  // Start-select decode; unused codes fall back to A.
  function automatic full_st_t decode_sel(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return ST_B;
      3'd2:    return ST_C;
      3'd3:    return ST_D;
      3'd4:    return ST_E;
      3'd5:    return ST_F;
      default: return ST_A;
    endcase
  endfunction

  function automatic cls_t class_of(input full_st_t s);
    case (s)
      ST_A, ST_C: return CL_AC;
      ST_B, ST_D: return CL_BD;
      ST_E:       return CL_E;
      default:    return CL_F;
    endcase
  endfunction

endpackage

// File: rtl/full_fsm.sv
module full_fsm
  import mealy_miter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] start_code,
  input  logic             step,
  input  logic             x,
  output logic             z
);

  full_st_t st_q, st_d;
  logic     z_c;

  always_comb begin
    st_d = st_q;
    z_c  = 1'b0;
    case (st_q)
      ST_A: begin st_d = x ? ST_D : ST_E; z_c = x; end
      ST_B: begin st_d = x ? ST_D : ST_F; z_c = 1'b0; end
      ST_C: begin st_d = x ? ST_B : ST_E; z_c = x; end
      ST_D: begin st_d = x ? ST_B : ST_F; z_c = 1'b0; end
      ST_E: begin st_d = x ? ST_F : ST_C; z_c = x; end
      ST_F: begin st_d = x ? ST_C : ST_B; z_c = 1'b0; end
      default: begin st_d = ST_A; z_c = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       st_q <= decode_sel(start_code);
    else if (step) st_q <= st_d;
  end

  assign z = z_c;

  // R7: no accepted bit, no state change
  a_r7_full_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(st_q));

  // R2: state stays inside the six legal codes
  a_r2_full_legal: assert property (@(posedge clk) disable iff (rst)
    step |=> (st_q <= ST_F));

endmodule

// File: rtl/class_fsm.sv
module class_fsm
  import mealy_miter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] start_code,
  input  logic             step,
  input  logic             x,
  output logic             z
);

  cls_t cl_q, cl_d;
  logic z_c;

  always_comb begin
    cl_d = cl_q;
    z_c  = 1'b0;
    case (cl_q)
      CL_AC: begin cl_d = x ? CL_BD : CL_E;  z_c = x; end
      CL_E:  begin cl_d = x ? CL_F  : CL_AC; z_c = x; end
      CL_BD: begin cl_d = x ? CL_BD : CL_F;  z_c = 1'b0; end
      default: begin cl_d = x ? CL_AC : CL_BD; z_c = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       cl_q <= class_of(decode_sel(start_code));
    else if (step) cl_q <= cl_d;
  end

  assign z = z_c;

  // R7: no accepted bit, no class change
  a_r7_class_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cl_q));

  // R3: the class holding B and D returns to itself on a one with output 0
  a_r3_bd_self_loop: assert property (@(posedge clk) disable iff (rst)
    (step && x && cl_q == CL_BD) |=> (cl_q == CL_BD));

endmodule

// File: rtl/miter_track.sv
module miter_track #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             z_a,
  input  logic             z_b,
  output logic             mismatch,
  output logic             err,
  output logic [CNT_W-1:0] first_idx
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_q;
  logic             err_q;

  assign mismatch = step & (z_a ^ z_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (step && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (mismatch && !err_q) begin
        err_q <= 1'b1;
        idx_q <= cnt_q;
      end
    end
  end

  assign err       = err_q;
  assign first_idx = idx_q;

  // R5: the flag sets after a mismatch and never drops
  a_r5_sets_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> err_q);
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R6: index frozen once the flag is up, count saturates
  a_r6_idx_frozen: assert property (@(posedge clk) disable iff (rst)
    err_q |=> $stable(idx_q));
  a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R4/R7: no accepted bit, no mismatch and no count change
  a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step |-> !mismatch);
  a_r7_cnt_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));

endmodule

// File: rtl/mealy_miter.sv
module mealy_miter
  import mealy_miter_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sel_a,
  input  logic [2:0]       sel_b,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             z_a,
  output logic             z_b,
  output logic             mismatch,
  output logic             err_flag,
  output logic [CNT_W-1:0] first_idx
);

  logic step;

  assign in_ready = ~rst;
  assign step     = in_valid & in_ready;

  full_fsm u_full (
    .clk        (clk),
    .rst        (rst),
    .start_code (sel_a),
    .step       (step),
    .x          (in_bit),
    .z          (z_a)
  );

  class_fsm u_class (
    .clk        (clk),
    .rst        (rst),
    .start_code (sel_b),
    .step       (step),
    .x          (in_bit),
    .z          (z_b)
  );

  miter_track #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .z_a       (z_a),
    .z_b       (z_b),
    .mismatch  (mismatch),
    .err       (err_flag),
    .first_idx (first_idx)
  );

  // R1: flags are clear on the edge after reset
  a_r1_clear_after_reset: assert property (@(posedge clk)
    rst |=> (!err_flag && first_idx == '0));

endmodule

// File: tb/test_mealy_miter.sv
module test_mealy_miter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_a = 3'd0;
  logic [2:0] sel_b = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready, z_a, z_b, mismatch, err_flag;
  logic [2:0] first_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mealy_miter i_mealy_miter (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .z_a(z_a), .z_b(z_b), .mismatch(mismatch),
    .err_flag(err_flag), .first_idx(first_idx)
  );

  // Bench model of the six-state table, codes 0..5 = A..F
  int nxt0 [6] = '{4, 5, 4, 5, 2, 1};
  int nxt1 [6] = '{3, 3, 1, 1, 5, 2};
  int out1 [6] = '{1, 0, 1, 0, 1, 0};
  int cls  [6] = '{0, 2, 0, 2, 1, 3};

  int m_a, m_b, m_cnt, m_idx;
  bit m_err;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec(input int code);
    return (code > 5) ? 0 : code;
  endfunction

  // R1: reset with given selects, then check the cleared state
  task automatic do_reset(input int a, input int b);
    @(negedge clk);
    rst = 1'b1; sel_a = a[2:0]; sel_b = b[2:0]; in_valid = 1'b0;
    #1 chk("R1 ready low in reset", int'(in_ready), 0);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 err clear", int'(err_flag), 0);
    chk("R1 idx clear", int'(first_idx), 0);
    m_a = dec(a); m_b = dec(b); m_cnt = 0; m_idx = 0; m_err = 0;
  endtask

  // One cycle: check registered flags, offer a bit, check Mealy outputs
  task automatic step(input bit x, input bit v);
    int ea, eb, emm;
    chk("R5 err_flag", int'(err_flag), int'(m_err));
    chk("R6 first_idx", int'(first_idx), m_idx);
    in_bit = x; in_valid = v;
    #1;
    ea = x ? out1[m_a] : 0;
    eb = x ? out1[m_b] : 0;
    emm = v ? (ea ^ eb) : 0;
    chk("R4 mismatch", int'(mismatch), emm);
    if (v) begin
      chk("R2 z_a", int'(z_a), ea);
      chk("R3 z_b", int'(z_b), eb);
      if (emm != 0 && !m_err) begin m_err = 1; m_idx = m_cnt; end
      if (m_cnt < 7) m_cnt++;
      m_a = x ? nxt1[m_a] : nxt0[m_a];
      m_b = x ? nxt1[m_b] : nxt0[m_b];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_a_vs_e_ones();
    do_reset(0, 4);
    step(1, 1); chk("R9 no mismatch on bit 1", int'(err_flag), 0);
    step(1, 1); chk("R9 no mismatch on bit 2", int'(err_flag), 0);
    step(1, 1);
    chk("R9 A/E mismatch after third", int'(err_flag), 1);
    chk("R9 A/E index", int'(first_idx), 2);
  endtask

  task automatic t_a_vs_b_one();
    do_reset(0, 1);
    step(1, 1);
    chk("R9 A/B mismatch at once", int'(err_flag), 1);
    chk("R9 A/B index", int'(first_idx), 0);
    step(0, 1); step(1, 1); step(1, 1);
    chk("R5 err stays set", int'(err_flag), 1);
    chk("R6 index held", int'(first_idx), 0);
  endtask

  task automatic t_idle_gaps();
    do_reset(2, 4);
    step(1, 0); step(1, 0);
    step(0, 1); step(1, 0); step(1, 1); step(1, 0); step(1, 1); step(1, 1);
    chk("R7 model flags after gaps", int'(err_flag), int'(m_err));
  endtask

  task automatic t_saturation();
    do_reset(0, 4);
    for (int i = 0; i < 9; i++) step(0, 1);
    step(1, 1); step(1, 1); step(1, 1);
    chk("R6 saturated index", int'(first_idx), 7);
    chk("R6 err set", int'(err_flag), 1);
  endtask

  task automatic t_bad_codes();
    do_reset(7, 0);
    for (int i = 0; i < 6; i++) step(i[0] ^ i[1], 1);
    chk("R1 code 7 acts as A", int'(err_flag), 0);
    do_reset(6, 2);
    for (int i = 0; i < 6; i++) step(1, 1);
    chk("R1 code 6 acts as A", int'(err_flag), 0);
  endtask

  task automatic t_all_pairs();
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        do_reset(a, b);
        for (int k = 0; k < 12; k++) step(1'($urandom & 1), 1'(($urandom % 5) != 0));
        step(0, 0);
        if (cls[a] == cls[b])
          chk("R8 same class never mismatches", int'(err_flag), 0);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_a_vs_e_ones();
    t_a_vs_b_one();
    t_idle_gaps();
    t_saturation();
    t_bad_codes();
    t_all_pairs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule